// File: doc/BRIEF.md
# Tributary Justification Decision Controller

This block decides, for a single tributary, whether each justification opportunity carries a positive justification, a negative justification, or none. It keeps its own occupancy count of the rate-adaptation FIFO from the FIFO's write and read strobes. The count is compared against two programmable levels, a high mark and a low mark. A mode input can instead make the decision follow external positive and negative request lines.

The chosen command is captured on the opportunity strobe and held until the next strobe. A downstream overhead encoder consumes it. The block also raises sticky flags when a write arrives at a full FIFO, when a read arrives at an empty FIFO, and when both external requests are raised together. A single clear input drops all three flags. A multi-tributary mapper uses one instance per tributary.

Top module: `tsj_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `fill_lvl` = 0, `just_cmd` = 2'b00, and `ovf_flag`, `unf_flag` and `req_err` all low.
- R2: The occupancy changes on each clock edge as follows:
  - a write without a read adds one;
  - a read without a write subtracts one;
  - a simultaneous write and read leaves it unchanged;
  - it never leaves the range 0 to DEPTH.
- R3: A write without a read while `fill_lvl` equals DEPTH leaves `fill_lvl` at DEPTH and sets `ovf_flag` in the next cycle.
- R4: A read without a write while `fill_lvl` is 0 leaves `fill_lvl` at 0 and sets `unf_flag` in the next cycle.
- R5: `ovf_flag`, `unf_flag` and `req_err` stay high until `clr_flags` is sampled high. When a new setting event and `clr_flags` occur in the same cycle, the flag ends up high.
- R6: With `ext_mode` low, a cycle with `opp_stb` high produces a new command in the next cycle, based on the `fill_lvl` value of the strobe cycle:
  - above `thr_hi`: negative justification, 2'b10;
  - otherwise, below `thr_lo`: positive justification, 2'b01;
  - otherwise: none, 2'b00.
- R7: `just_cmd` changes only in the cycle after a cycle with `opp_stb` high. It holds its value otherwise, and never takes the value 2'b11.
- R8: With `ext_mode` high, a strobe cycle decides the command from the requests alone, whatever `fill_lvl` is:
  - `ext_pos_req` alone: 2'b01;
  - `ext_neg_req` alone: 2'b10;
  - neither request: 2'b00.
- R9: With `ext_mode` high, a strobe cycle in which both requests are high produces 2'b00 and sets `req_err` in the next cycle. The two requests together set nothing when `opp_stb` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | FIFO write strobe |
| rd_en | input | 1 | FIFO read strobe |
| thr_hi | input | CNT_W | High occupancy mark |
| thr_lo | input | CNT_W | Low occupancy mark |
| ext_mode | input | 1 | 0: decide from occupancy, 1: decide from external requests |
| ext_pos_req | input | 1 | External positive justification request |
| ext_neg_req | input | 1 | External negative justification request |
| opp_stb | input | 1 | Justification opportunity strobe |
| clr_flags | input | 1 | Clears the sticky flags |
| just_cmd | output | 2 | Held command: 00 none, 01 positive, 10 negative |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |
| req_err | output | 1 | Sticky flag for conflicting external requests |
| fill_lvl | output | CNT_W | Current occupancy |

## Verification
The hardest situation to reach is a flag-setting event that coincides with `clr_flags`. It needs the FIFO driven fully to DEPTH, or drained to zero, and then one more unmatched strobe arriving together with the clear.

The stimulus reaches it by filling the FIFO with writes first. While filling, it fires opportunity strobes so that every threshold band is crossed. It then pushes a write against the full FIFO in the same cycle as a clear, and does the same with a read against the empty FIFO.

Misordered marks (high mark below low mark), conflicting external requests and a long stretch of random traffic complete the stimulus. A behavioural reference model is compared on every cycle throughout.

// File: rtl/tsj_pkg.sv
// Shared types for the justification controller.
package tsj_pkg;
    typedef enum logic [1:0] {
        JC_NONE = 2'b00,
        JC_POS  = 2'b01,
        JC_NEG  = 2'b10
    } jcmd_e;
endpackage

// File: rtl/tsj_fill_track.sv
// Occupancy tracker: counts FIFO entries from write/read strobes.
// Assumes the strobes describe the FIFO exactly. It saturates at 0 and DEPTH
// and reports unmatched strobes at the limits as single-cycle events.
module tsj_fill_track #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic [CNT_W-1:0] fill,
    output logic             ovf_evt,
    output logic             unf_evt
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic push_only;
    logic pop_only;

    // Classify this cycle's strobes and detect the limit violations.
    always_comb begin
        push_only = wr_en && !rd_en;
        pop_only  = rd_en && !wr_en;
        ovf_evt   = push_only && (fill == FULL);
        unf_evt   = pop_only && (fill == '0);
    end

    // Update the occupancy, holding it at the limits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill <= '0;
        end else if (push_only && !ovf_evt) begin
            fill <= fill + 1'b1;
        end else if (pop_only && !unf_evt) begin
            fill <= fill - 1'b1;
        end
    end
endmodule

// File: rtl/tsj_decide.sv
// Justification decision: on each opportunity strobe, registers a command
// taken from the occupancy marks or from the external requests.
// Assumes the marks are quasi-static. A high occupancy takes priority when
// the marks are misordered.
module tsj_decide #(
    parameter int CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opp_stb,
    input  logic              ext_mode,
    input  logic              pos_req,
    input  logic              neg_req,
    input  logic [CNT_W-1:0]  fill,
    input  logic [CNT_W-1:0]  thr_hi,
    input  logic [CNT_W-1:0]  thr_lo,
    output tsj_pkg::jcmd_e    cmd,
    output logic              clash_evt
);
    import tsj_pkg::*;

    jcmd_e nxt;

    // Work out the command that the current strobe would commit.
    always_comb begin
        nxt       = JC_NONE;
        clash_evt = 1'b0;
        if (ext_mode) begin
            if (pos_req && neg_req) begin
                clash_evt = opp_stb;
            end else if (pos_req) begin
                nxt = JC_POS;
            end else if (neg_req) begin
                nxt = JC_NEG;
            end
        end else if (fill > thr_hi) begin
            nxt = JC_NEG;
        end else if (fill < thr_lo) begin
            nxt = JC_POS;
        end
    end

    // Commit on the strobe and hold the command between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd <= JC_NONE;
        end else if (opp_stb) begin
            cmd <= nxt;
        end
    end
endmodule

// File: rtl/tsj_sticky.sv
// Bank of sticky flags: each bit is set by its event and dropped by a shared
// clear. A set beats the clear in the same cycle, so no event is lost.
module tsj_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_evt,
    input  logic         clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Hold one flag until it is cleared.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (set_evt[i]) begin
                flags[i] <= 1'b1;
            end else if (clr) begin
                flags[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tsj_ctrl.sv
// Per-tributary justification controller top. It ties the occupancy tracker,
// the decision stage and the sticky flag bank together.
// Assumes one instance per tributary with all inputs synchronous to clk.
module tsj_ctrl #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [CNT_W-1:0] thr_hi,
    input  logic [CNT_W-1:0] thr_lo,
    input  logic             ext_mode,
    input  logic             ext_pos_req,
    input  logic             ext_neg_req,
    input  logic             opp_stb,
    input  logic             clr_flags,
    output logic [1:0]       just_cmd,
    output logic             ovf_flag,
    output logic             unf_flag,
    output logic             req_err,
    output logic [CNT_W-1:0] fill_lvl
);
    localparam int NFLAG = 3;

    logic           ovf_evt;
    logic           unf_evt;
    logic           clash_evt;
    tsj_pkg::jcmd_e cmd;
    logic [NFLAG-1:0] flag_q;

    tsj_fill_track #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fill (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .fill    (fill_lvl),
        .ovf_evt (ovf_evt),
        .unf_evt (unf_evt)
    );

    tsj_decide #(.CNT_W(CNT_W)) u_decide (
        .clk       (clk),
        .rst_n     (rst_n),
        .opp_stb   (opp_stb),
        .ext_mode  (ext_mode),
        .pos_req   (ext_pos_req),
        .neg_req   (ext_neg_req),
        .fill      (fill_lvl),
        .thr_hi    (thr_hi),
        .thr_lo    (thr_lo),
        .cmd       (cmd),
        .clash_evt (clash_evt)
    );

    tsj_sticky #(.N(NFLAG)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt ({clash_evt, unf_evt, ovf_evt}),
        .clr     (clr_flags),
        .flags   (flag_q)
    );

    // Drive the output ports from the sub-block results.
    always_comb begin
        just_cmd = cmd;
        ovf_flag = flag_q[0];
        unf_flag = flag_q[1];
        req_err  = flag_q[2];
    end
endmodule

// File: rtl/tsj_ctrl_chk.sv
// Port-level property checker for tsj_ctrl, attached with bind.
module tsj_ctrl_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [CNT_W-1:0] thr_hi,
    input logic [CNT_W-1:0] thr_lo,
    input logic             ext_mode,
    input logic             ext_pos_req,
    input logic             ext_neg_req,
    input logic             opp_stb,
    input logic             clr_flags,
    input logic [1:0]       just_cmd,
    input logic             ovf_flag,
    input logic             unf_flag,
    input logic             req_err,
    input logic [CNT_W-1:0] fill_lvl
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    assert_fill_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_lvl <= FULL);

    assert_fill_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en) |=> $stable(fill_lvl));

    assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && fill_lvl == FULL) |=> (ovf_flag && fill_lvl == FULL));

    assert_unf_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && fill_lvl == '0) |=> (unf_flag && fill_lvl == '0));

    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_flags) |=> ovf_flag);

    assert_unf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_flag && !clr_flags) |=> unf_flag);

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_err && !clr_flags) |=> req_err);

    assert_thr_neg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (opp_stb && !ext_mode && fill_lvl > thr_hi) |=> just_cmd == 2'b10);

    assert_thr_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (opp_stb && !ext_mode && !(fill_lvl > thr_hi) && fill_lvl < thr_lo)
        |=> just_cmd == 2'b01);

    assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !opp_stb |=> $stable(just_cmd));

    assert_cmd_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        just_cmd != 2'b11);

    assert_ext_pos_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (opp_stb && ext_mode && ext_pos_req && !ext_neg_req) |=> just_cmd == 2'b01);

    assert_ext_neg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (opp_stb && ext_mode && ext_neg_req && !ext_pos_req) |=> just_cmd == 2'b10);

    assert_req_clash_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (opp_stb && ext_mode && ext_pos_req && ext_neg_req)
        |=> (just_cmd == 2'b00 && req_err));
endmodule

bind tsj_ctrl tsj_ctrl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/tsj_ctrl_tb_top.sv
`timescale 1ns/1ps
module tsj_ctrl_tb_top;
    localparam int DEPTH = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [CNT_W-1:0] thr_hi = CNT_W'(12);
    logic [CNT_W-1:0] thr_lo = CNT_W'(4);
    logic             ext_mode = 1'b0;
    logic             ext_pos_req = 1'b0;
    logic             ext_neg_req = 1'b0;
    logic             opp_stb = 1'b0;
    logic             clr_flags = 1'b0;
    logic [1:0]       just_cmd;
    logic             ovf_flag;
    logic             unf_flag;
    logic             req_err;
    logic [CNT_W-1:0] fill_lvl;

    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string tag = "R1";

    // Behavioural reference state.
    int m_fill = 0;
    int m_cmd = 0;
    bit m_ovf = 0;
    bit m_unf = 0;
    bit m_err = 0;

    always #2.5 clk = ~clk;

    tsj_ctrl #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .thr_hi(thr_hi), .thr_lo(thr_lo), .ext_mode(ext_mode),
        .ext_pos_req(ext_pos_req), .ext_neg_req(ext_neg_req),
        .opp_stb(opp_stb), .clr_flags(clr_flags), .just_cmd(just_cmd),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag), .req_err(req_err),
        .fill_lvl(fill_lvl)
    );

    task automatic model_update();
        bit so, su, se;
        if (!rst_n) begin
            m_fill = 0; m_cmd = 0; m_ovf = 0; m_unf = 0; m_err = 0;
            return;
        end
        so = wr_en && !rd_en && m_fill == DEPTH;
        su = rd_en && !wr_en && m_fill == 0;
        se = opp_stb && ext_mode && ext_pos_req && ext_neg_req;
        if (opp_stb) begin
            if (ext_mode) begin
                if (ext_pos_req && ext_neg_req) m_cmd = 0;
                else if (ext_pos_req) m_cmd = 1;
                else if (ext_neg_req) m_cmd = 2;
                else m_cmd = 0;
            end else begin
                if (m_fill > int'(thr_hi)) m_cmd = 2;
                else if (m_fill < int'(thr_lo)) m_cmd = 1;
                else m_cmd = 0;
            end
        end
        if (so) m_ovf = 1; else if (clr_flags) m_ovf = 0;
        if (su) m_unf = 1; else if (clr_flags) m_unf = 0;
        if (se) m_err = 1; else if (clr_flags) m_err = 0;
        if (wr_en && !rd_en && m_fill < DEPTH) m_fill++;
        else if (rd_en && !wr_en && m_fill > 0) m_fill--;
    endtask

    task automatic compare();
        checks++;
        if (int'(fill_lvl) != m_fill || int'(just_cmd) != m_cmd ||
            ovf_flag != m_ovf || unf_flag != m_unf || req_err != m_err) begin
            fails++;
            $display("FAIL %s: actual fill=%0d cmd=%0d ovf=%0b unf=%0b err=%0b expected fill=%0d cmd=%0d ovf=%0b unf=%0b err=%0b",
                     tag, fill_lvl, just_cmd, ovf_flag, unf_flag, req_err,
                     m_fill, m_cmd, m_ovf, m_unf, m_err);
        end
    endtask

    task automatic cyc(input bit w, input bit r, input bit o, input bit c);
        wr_en = w; rd_en = r; opp_stb = o; clr_flags = c;
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        // R1: reset state
        tag = "R1";
        wr_en = 1'b1; opp_stb = 1'b1;
        repeat (3) cyc(1, 0, 1, 0);
        rst_n = 1'b1;
        cyc(0, 0, 0, 0);

        // R2 and R6: fill upward with strobes crossing every band
        tag = "R6";
        for (int i = 0; i < 16; i++) cyc(1, 0, (i % 3) == 0, 0);
        cyc(0, 0, 1, 0);

        // R3: writes against a full FIFO
        tag = "R3";
        cyc(1, 0, 0, 0);
        cyc(1, 0, 0, 0);

        // R5: the clear alone, then a set together with the clear
        tag = "R5";
        cyc(0, 0, 0, 1);
        cyc(1, 0, 0, 1);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 1);

        // R2: simultaneous write and read
        tag = "R2";
        cyc(1, 1, 0, 0);
        cyc(1, 1, 1, 0);

        // R7: strobe once, then change the fill without a strobe
        tag = "R7";
        cyc(0, 0, 1, 0);
        for (int i = 0; i < 10; i++) cyc(0, 1, 0, 0);

        // R6: drain with strobes; R4: reads against an empty FIFO
        tag = "R4";
        for (int i = 0; i < 9; i++) cyc(0, 1, (i % 2) == 0, 0);
        cyc(0, 0, 1, 0);
        cyc(0, 1, 0, 1);
        cyc(0, 0, 0, 1);

        // R6: misordered marks, a high occupancy must win
        tag = "R6";
        thr_hi = CNT_W'(3); thr_lo = CNT_W'(10);
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0);
        cyc(0, 0, 1, 0);
        cyc(0, 0, 0, 0);
        thr_hi = CNT_W'(12); thr_lo = CNT_W'(4);

        // R8: external requests ignore the occupancy
        tag = "R8";
        ext_mode = 1'b1;
        ext_pos_req = 1'b1; cyc(0, 0, 1, 0);
        ext_pos_req = 1'b0; ext_neg_req = 1'b1; cyc(0, 0, 1, 0);
        ext_neg_req = 1'b0; cyc(0, 0, 1, 0);
        ext_pos_req = 1'b1; cyc(0, 0, 0, 0);

        // R9: both requests, with and without a strobe
        tag = "R9";
        ext_neg_req = 1'b1; cyc(0, 0, 0, 0);
        cyc(0, 0, 1, 0);
        cyc(0, 0, 0, 0);
        ext_pos_req = 1'b0; ext_neg_req = 1'b0;
        cyc(0, 0, 0, 1);
        ext_mode = 1'b0;

        // R2: random traffic under both modes
        tag = "R2";
        for (int i = 0; i < 600; i++) begin
            ext_mode    = (i >= 400);
            ext_pos_req = 1'($urandom);
            ext_neg_req = 1'($urandom);
            cyc(1'($urandom), 1'($urandom), ($urandom % 4) == 0, ($urandom % 16) == 0);
        end

        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end
endmodule